// File: doc/BRIEF.md
# Three-Bank Memory-Mapped GPIO Controller

This block drives and senses general-purpose pins organised as banks of 32, three banks by default. It sits on a plain 32-bit register bus that has a select, a write enable, a byte address and write data. Read data is combinational on the address. Each pin has a direction bit. Outputs change only through atomic set and clear words, so software can move one pin without a read-modify-write.

Every pad input passes through a two-flop synchroniser and an optional per-pin inversion. The resulting sensed level feeds three things: the level readback, edge detection for rising and falling edges, and level matching for high and low. Any enabled event latches a status bit. The status bit stays set until software writes a 1 to it. A single interrupt line is the OR of every status bit in every bank.

The address map is register-major. Register kind k of bank b sits at byte offset k*16 + b*4. One 16-byte slot therefore holds one word per bank, inside a 256-byte window.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: A register is at byte offset kind*0x10 + bank*4, with bank 0..2 and kind 0 direction, 1 invert, 2 level, 3 set, 4 clear, 5 rise-enable, 6 fall-enable, 7 high-enable, 8 low-enable, 9 status, 10 edge-kind. Reads return the addressed word in the same cycle.
- R2: A 1 in the direction word makes a pin an output and drives its `pin_oe` bit high; a 0 makes it an input. The word reads back as written.
- R3: Writing 1s to the set word drives those pins' `pin_out` bits high, and writing 1s to the clear word drives them low. Zero bits leave pins unchanged. Both words read as zero.
- R4: `pin_out` changes only through set and clear writes. A write to the level word has no effect.
- R5: The level word reads the output latch for output pins and the synchronised, inverted-if-enabled pad level for input pins. A pad change shows there two clocks after it is captured.
- R6: A 1 in the invert word inverts that pin's sensed level before readback and before event detection. Changing the invert bit counts as a sensed-level change.
- R7: A sensed rising (falling) edge on a pin with its rise (fall) enable set sets its status bit. It also records the edge-kind bit: 1 for rising, 0 for falling.
- R8: While a pin's high (low) enable is set and its sensed level is 1 (0), its status bit is set.
- R9: Writing a 1 to a status bit clears it. An event in the same cycle keeps it set. Status bits never fall without such a write.
- R10: `irq` is high exactly when any status bit in any bank is set.
- R11: Offsets with nonzero low two bits, bank field 3, or kind above 10 read as zero, and writes to them change nothing.
- R12: After reset every register, `pin_out`, `pin_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per write |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 96 | Pad input levels, bank 0 in the low 32 bits |
| pin_out | output | 96 | Output latch levels |
| pin_oe | output | 96 | Output enables (1 = drive) |
| irq | output | 1 | OR of all status bits |

## Verification
The properties assume a bus write is held for exactly one clock edge. They also assume pads change slowly relative to the two-flop synchroniser, so each pad transition is seen once. The stimulus changes pads only at falling clock edges and holds them for at least five cycles. It waits three cycles after every write before it reads. This lets every event caused by an invert, enable or pad change settle before the next operation, which matches the transaction-level expectations the bench computes.

// File: rtl/gpio_bk_pkg.sv
// Package: shared register kinds and address field sizes for the banked GPIO controller.
// Assumes a register-major map with 16-byte slots, one 32-bit word per bank.
package gpio_bk_pkg;
    localparam int REG_IDX_W  = 4;
    localparam int BANK_SEL_W = 2;
    localparam int REG_COUNT  = 11;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_DIR       = 4'd0,
        RG_INV       = 4'd1,
        RG_LEVEL     = 4'd2,
        RG_SET       = 4'd3,
        RG_CLR       = 4'd4,
        RG_RISE_EN   = 4'd5,
        RG_FALL_EN   = 4'd6,
        RG_HIGH_EN   = 4'd7,
        RG_LOW_EN    = 4'd8,
        RG_STATUS    = 4'd9,
        RG_EDGE_KIND = 4'd10
    } gpio_reg_e;
endpackage

// File: rtl/gpio_bk_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is provided.
module gpio_bk_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture then re-register the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_bk_decode.sv
// Module: splits a byte offset into register kind and bank, and flags mapped words.
// Assumes kind in bits [ADDR_W-1:4], bank in [3:2], and word alignment required.
module gpio_bk_decode
    import gpio_bk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [BANK_SEL_W-1:0] bank_idx,
    output gpio_reg_e             reg_idx
);
    localparam int RF_W = ADDR_W - 4;

    logic [RF_W-1:0] kind_field;

    // Field extraction and mapped-word test.
    always_comb begin
        kind_field = addr[ADDR_W-1:4];
        bank_idx   = addr[3:2];
        reg_idx    = gpio_reg_e'(kind_field[REG_IDX_W-1:0]);
        hit        = (addr[1:0] == 2'b00)
                   && ({1'b0, bank_idx} < (BANK_SEL_W+1)'(NUM_BANKS))
                   && (kind_field < RF_W'(REG_COUNT));
    end
endmodule

// File: rtl/gpio_bk_bank.sv
// Module: one bank of pins: configuration words, output latch, input sensing,
// edge and level events, sticky status and edge-kind record.
// Assumes wr_stb is one cycle per bus write and already qualified by address.
module gpio_bk_bank
    import gpio_bk_pkg::*;
#(
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  gpio_reg_e     reg_sel,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] pin_raw,
    output logic [BW-1:0] pin_out,
    output logic [BW-1:0] pin_oe,
    output logic [BW-1:0] rd_data,
    output logic [BW-1:0] stat_q,
    output logic          stat_any
);
    logic [BW-1:0] dir_q, inv_q, out_q;
    logic [BW-1:0] rise_en_q, fall_en_q, high_en_q, low_en_q;
    logic [BW-1:0] kind_q, prev_q;
    logic [BW-1:0] pin_s, sensed;
    logic [BW-1:0] ev_rise, ev_fall, ev_level, clr_mask;

    gpio_bk_sync #(.W(BW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .d_sync  (pin_s)
    );

    // Sensed level and event vectors.
    always_comb begin
        sensed   = pin_s ^ inv_q;
        ev_rise  = sensed & ~prev_q & rise_en_q;
        ev_fall  = ~sensed & prev_q & fall_en_q;
        ev_level = (sensed & high_en_q) | (~sensed & low_en_q);
        clr_mask = (wr_stb && reg_sel == RG_STATUS) ? wdata : '0;
    end

    // Configuration words written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            inv_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            high_en_q <= '0;
            low_en_q  <= '0;
        end else if (wr_stb) begin
            case (reg_sel)
                RG_DIR:     dir_q     <= wdata;
                RG_INV:     inv_q     <= wdata;
                RG_RISE_EN: rise_en_q <= wdata;
                RG_FALL_EN: fall_en_q <= wdata;
                RG_HIGH_EN: high_en_q <= wdata;
                RG_LOW_EN:  low_en_q  <= wdata;
                default:    ;
            endcase
        end
    end

    // Output latch: atomic set and clear only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_stb && reg_sel == RG_SET) begin
            out_q <= out_q | wdata;
        end else if (wr_stb && reg_sel == RG_CLR) begin
            out_q <= out_q & ~wdata;
        end
    end

    // Previous sensed level, sticky status (set wins) and last edge kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
            kind_q <= '0;
        end else begin
            prev_q <= sensed;
            stat_q <= (stat_q & ~clr_mask) | ev_rise | ev_fall | ev_level;
            kind_q <= (kind_q & ~(ev_rise | ev_fall)) | ev_rise;
        end
    end

    // Read multiplexer for this bank.
    always_comb begin
        case (reg_sel)
            RG_DIR:       rd_data = dir_q;
            RG_INV:       rd_data = inv_q;
            RG_LEVEL:     rd_data = (dir_q & out_q) | (~dir_q & sensed);
            RG_RISE_EN:   rd_data = rise_en_q;
            RG_FALL_EN:   rd_data = fall_en_q;
            RG_HIGH_EN:   rd_data = high_en_q;
            RG_LOW_EN:    rd_data = low_en_q;
            RG_STATUS:    rd_data = stat_q;
            RG_EDGE_KIND: rd_data = kind_q;
            default:      rd_data = '0;
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe   = dir_q;
    assign stat_any = |stat_q;
endmodule

// File: rtl/gpio_banked_ctrl.sv
// Module: top of the banked GPIO controller; decodes the bus, instantiates
// one bank slice per bank and merges read data and interrupt.
// Assumes a single-cycle write strobe and combinational reads on bus_addr.
module gpio_banked_ctrl
    import gpio_bk_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*DATA_W-1:0] pin_in,
    output logic [NUM_BANKS*DATA_W-1:0] pin_out,
    output logic [NUM_BANKS*DATA_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int PIN_W = NUM_BANKS * DATA_W;

    logic                  hit;
    logic [BANK_SEL_W-1:0] bank_idx;
    gpio_reg_e             reg_idx;
    logic [DATA_W-1:0]     bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;
    logic [PIN_W-1:0]      stat_all;

    gpio_bk_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .bank_idx (bank_idx),
        .reg_idx  (reg_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_stb;
        assign wr_stb = bus_sel && bus_we && hit && (bank_idx == BANK_SEL_W'(b));

        gpio_bk_bank #(.BW(DATA_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_stb),
            .reg_sel  (reg_idx),
            .wdata    (bus_wdata),
            .pin_raw  (pin_in[b*DATA_W +: DATA_W]),
            .pin_out  (pin_out[b*DATA_W +: DATA_W]),
            .pin_oe   (pin_oe[b*DATA_W +: DATA_W]),
            .rd_data  (bank_rd[b]),
            .stat_q   (stat_all[b*DATA_W +: DATA_W]),
            .stat_any (bank_irq[b])
        );
    end

    // Select the addressed bank's word; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit && bank_idx == BANK_SEL_W'(b)) begin
                bus_rdata = bank_rd[b];
            end
        end
    end

    assign irq = |bank_irq;
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
// Module: property checker for gpio_banked_ctrl, attached with bind.
// Assumes the same parameters as the bound top.
module gpio_banked_ctrl_chk #(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_BANKS*DATA_W-1:0] pin_out,
    input logic [NUM_BANKS*DATA_W-1:0] pin_oe,
    input logic                        irq,
    input logic [NUM_BANKS*DATA_W-1:0] stat_all
);
    localparam int RF_W = ADDR_W - 4;

    logic [RF_W-1:0] kind_f;
    logic            wr_any;
    assign kind_f = bus_addr[ADDR_W-1:4];
    assign wr_any = bus_sel && bus_we;

    a_r10_irq_any_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_all != '0));

    a_r11_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    a_r11_high_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_f > RF_W'(10)) |-> (bus_rdata == '0));

    a_r2_oe_only_by_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && kind_f == RF_W'(0)) |=> $stable(pin_oe));

    a_r4_out_only_by_set_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && (kind_f == RF_W'(3) || kind_f == RF_W'(4))) |=> $stable(pin_out));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && kind_f == RF_W'(9)) |=> (($past(stat_all) & ~stat_all) == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_any && bus_addr == ADDR_W'(3*16 + b*4))
            |=> ((pin_out[b*DATA_W +: DATA_W] & $past(bus_wdata)) == $past(bus_wdata)));

        a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_any && bus_addr == ADDR_W'(4*16 + b*4))
            |=> ((pin_out[b*DATA_W +: DATA_W] & $past(bus_wdata)) == '0));
    end
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat_all  (stat_all)
);

// File: tb/gpio_banked_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// transaction-level model kept in bench functions.
module gpio_banked_ctrl_bench;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out;
    logic [95:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_dir [NB], m_inv [NB], m_out [NB];
    logic [31:0] m_ren [NB], m_fen [NB], m_hen [NB], m_len [NB];
    logic [31:0] m_stat [NB], m_kind [NB];

    always #2.5 clk = ~clk;

    gpio_banked_ctrl u_gpio_banked_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    function automatic logic [31:0] sensed_of(int b, logic [95:0] pins, logic [31:0] inv);
        return pins[b*32 +: 32] ^ inv;
    endfunction

    function automatic void apply_events(int b, logic [31:0] olds, logic [31:0] news);
        logic [31:0] er, ef;
        er = news & ~olds & m_ren[b];
        ef = ~news & olds & m_fen[b];
        m_stat[b] = m_stat[b] | er | ef;
        m_kind[b] = (m_kind[b] & ~(er | ef)) | er;
    endfunction

    function automatic void apply_levels();
        for (int b = 0; b < NB; b++) begin
            logic [31:0] s;
            s = sensed_of(b, pin_in, m_inv[b]);
            m_stat[b] = m_stat[b] | (s & m_hen[b]) | (~s & m_len[b]);
        end
    endfunction

    function automatic bit mapped(logic [7:0] a);
        return (a[1:0] == 2'b00) && (int'(a[3:2]) < NB) && (int'(a[7:4]) <= 10);
    endfunction

    function automatic void model_write(logic [7:0] a, logic [31:0] d);
        int b, r;
        logic [31:0] olds;
        if (!mapped(a)) return;
        b = int'(a[3:2]);
        r = int'(a[7:4]);
        case (r)
            0: m_dir[b] = d;
            1: begin
                olds = sensed_of(b, pin_in, m_inv[b]);
                m_inv[b] = d;
                apply_events(b, olds, sensed_of(b, pin_in, m_inv[b]));
            end
            3: m_out[b] = m_out[b] | d;
            4: m_out[b] = m_out[b] & ~d;
            5: m_ren[b] = d;
            6: m_fen[b] = d;
            7: m_hen[b] = d;
            8: m_len[b] = d;
            9: m_stat[b] = m_stat[b] & ~d;
            default: ;
        endcase
        apply_levels();
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        int b, r;
        if (!mapped(a)) return '0;
        b = int'(a[3:2]);
        r = int'(a[7:4]);
        case (r)
            0: return m_dir[b];
            1: return m_inv[b];
            2: return (m_dir[b] & m_out[b]) | (~m_dir[b] & sensed_of(b, pin_in, m_inv[b]));
            5: return m_ren[b];
            6: return m_fen[b];
            7: return m_hen[b];
            8: return m_len[b];
            9: return m_stat[b];
            10: return m_kind[b];
            default: return '0;
        endcase
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ports(string req);
        logic any;
        any = 1'b0;
        for (int b = 0; b < NB; b++) any = any | (m_stat[b] != 0);
        n_chk++;
        if (pin_oe !== {m_dir[2], m_dir[1], m_dir[0]}) begin
            n_fail++;
            $display("FAIL %s pin_oe: actual %h expected %h", req, pin_oe, {m_dir[2], m_dir[1], m_dir[0]});
        end
        n_chk++;
        if (pin_out !== {m_out[2], m_out[1], m_out[0]}) begin
            n_fail++;
            $display("FAIL %s pin_out: actual %h expected %h", req, pin_out, {m_out[2], m_out[1], m_out[0]});
        end
        n_chk++;
        if (irq !== any) begin
            n_fail++;
            $display("FAIL %s irq: actual %b expected %b", req, irq, any);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        model_write(a, d);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_reg(string req, logic [7:0] a);
        logic [31:0] got;
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
        #1;
        got = bus_rdata;
        bus_sel = 1'b0;
        check32(req, got, model_read(a));
    endtask

    task automatic set_pins(logic [95:0] nv);
        @(negedge clk);
        for (int b = 0; b < NB; b++)
            apply_events(b, sensed_of(b, pin_in, m_inv[b]), sensed_of(b, nv, m_inv[b]));
        pin_in = nv;
        apply_levels();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [7:0] ad(int kind, int bank);
        return 8'(kind * 16 + bank * 4);
    endfunction

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '0; m_inv[b] = '0; m_out[b] = '0; m_ren[b] = '0; m_fen[b] = '0;
            m_hen[b] = '0; m_len[b] = '0; m_stat[b] = '0; m_kind[b] = '0;
        end
        void'($urandom(32'h0005EED5));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state of ports and every mapped word
        check_ports("R12");
        for (int k = 0; k <= 10; k++)
            for (int b = 0; b < NB; b++) check_reg("R12", ad(k, b));

        // R1 R2: direction word of bank 1 only
        bus_write(ad(0, 1), 32'hA5A5_0001);
        check_reg("R1", ad(0, 1));
        check_reg("R1", ad(0, 0));
        check_ports("R2");

        // R3: set then clear on bank 2; set/clear words read zero
        bus_write(ad(3, 2), 32'h0000_FF00);
        bus_write(ad(4, 2), 32'h0000_0F00);
        check32("R3", pin_out[95:64], 32'h0000_F000);
        check_reg("R3", ad(3, 2));
        check_reg("R3", ad(4, 2));

        // R4: write to level word has no effect
        bus_write(ad(2, 2), 32'hFFFF_FFFF);
        check_ports("R4");

        // R5: level readback mixes latch and pad
        bus_write(ad(0, 2), 32'h0000_FF00);
        set_pins({32'h1234_5678, 32'h0, 32'h0F0F_0F0F});
        check_reg("R5", ad(2, 2));
        check_reg("R5", ad(2, 0));

        // R6: inversion changes readback
        bus_write(ad(1, 0), 32'h0000_00FF);
        check_reg("R6", ad(2, 0));

        // R7: rising and falling edges on bank 1 bit 3
        bus_write(ad(5, 1), 32'h0000_0008);
        bus_write(ad(6, 1), 32'h0000_0008);
        set_pins(pin_in | (96'h8 << 32));
        check_reg("R7", ad(9, 1));
        check_reg("R7", ad(10, 1));
        check_ports("R10");
        bus_write(ad(9, 1), 32'h0000_0008);
        check_reg("R9", ad(9, 1));
        set_pins(pin_in & ~(96'h8 << 32));
        check_reg("R7", ad(9, 1));
        check_reg("R7", ad(10, 1));

        // R9: clear status, irq drops
        bus_write(ad(9, 1), 32'hFFFF_FFFF);
        check_reg("R9", ad(9, 1));
        check_ports("R10");

        // R8: high-level match holds status set through a clear
        bus_write(ad(7, 2), 32'h0000_0010);
        set_pins(pin_in | (96'h10 << 64));
        bus_write(ad(9, 2), 32'h0000_0010);
        check_reg("R8", ad(9, 2));
        bus_write(ad(7, 2), 32'h0);
        bus_write(ad(9, 2), 32'hFFFF_FFFF);
        check_reg("R8", ad(9, 2));

        // R11: unmapped offsets
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h31, 32'hFFFF_FFFF);
        bus_write(8'hB0, 32'hFFFF_FFFF);
        check_ports("R11");
        check_reg("R11", 8'h0C);
        check_reg("R11", 8'h01);
        check_reg("R11", 8'hB4);
        check_reg("R11", 8'hF0);

        // Random traffic, all requirements via the model
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 10);
            a = 8'(($urandom % 12) * 16 + ($urandom % 4) * 4 + (($urandom % 8) == 0 ? 1 : 0));
            if (op < 5) begin
                bus_write(a, $urandom);
                check_ports("R1");
            end else if (op < 7) begin
                set_pins({$urandom, $urandom, $urandom});
                check_ports("R7");
            end else begin
                check_reg("R1", a);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule